// File: doc/BRIEF.md
# DDR2 Eight-Bank Interleaved Read Pattern Generator

This block drives a DDR2 command bus with an endless all-bank interleaved read stream. It is meant for worst-case supply-current characterization of a memory device. Each bank is opened with an activate command. On the very next clock the same bank receives a read with auto-precharge. The banks are visited in ascending order, 0 to 7. Deselect slots are placed between banks so that the activate-to-activate spacing, the four-activate window and the same-bank row-cycle time are all met at a 2.5 ns clock.

A single organization input picks the by-8 or the by-16 slot spacing. The generator latches that input only while reset is high or enable is low, so a running pass always finishes with the spacing it started with. When enable is low, the bus idles with deselects and the pattern rewinds to bank 0. A one-clock wrap pulse marks the last slot of every pass. All outputs come from registers, and each slot appears one clock after the edge that sampled enable high.

Top module: `ddr_ilv_gen`

## Requirements
- R1: While reset is high, and on the first clock after it, the bus shows deselect, `ddr_ba` is 0, `ddr_addr` is 0 and `pass_wrap` is 0.
- R2: Banks are visited in the order 0,1,...,7, then the order repeats. Each activate is followed on the next clock by a read with auto-precharge to the same bank.
- R3: The command pins {cs_n,ras_n,cas_n,we_n} take one of three values: activate is 0,0,1,1; read is 0,1,0,1; deselect is 1,1,1,1. No other value is driven.
- R4: An activate carries the row word 0x01A5 on `ddr_addr`. A read carries the column word 0x0008 with bit 10 set, which gives 0x0408.
- R5: With `org_x16`=0 (by-8), each bank takes 3 slots: activate, read, deselect. Two extra deselects follow banks 3 and 7, so a pass is 28 clocks.
- R6: With `org_x16`=1 (by-16), each bank takes 4 slots: activate, read, deselect, deselect. Two extra deselects follow banks 3 and 7, so a pass is 36 clocks.
- R7: The first and fifth of any five consecutive activates are at least 14 clocks apart in by-8 mode and at least 18 clocks apart in by-16 mode.
- R8: Two activates to the same bank are exactly one pass apart, which is at least 23 clocks.
- R9: In a deselect slot, `ddr_ba` and `ddr_addr` keep the values they had in the previous clock.
- R10: `pass_wrap` is high for exactly one clock, on the final slot of each pass. That slot is a deselect.
- R11: One clock after enable is sampled low, the bus shows deselect and stays there while enable stays low. The next pass starts with an activate to bank 0.
- R12: A change on `org_x16` while enable is high has no effect until enable has been low, or reset high, for at least one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run the pattern; low forces deselect and rewinds |
| org_x16 | input | 1 | 0 = by-8 spacing, 1 = by-16 spacing |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | 3 | Bank address |
| ddr_addr | output | 14 | Row or column address |
| pass_wrap | output | 1 | High on the last slot of a pass |

## Verification
A wrong slot counter inside a bank shows up as a wrong command on the pins within one clock. It then shifts every later activate, so the spacing checks and the wrap-period check fail before the pass ends. A bank counter that skips a value, or that rewinds at the wrong point, makes the very next activate carry the wrong bank. An organization latch that follows the input at the wrong time moves the next wrap away from 28 or 36 clocks. It also changes the command seen within four slots of the change. A fault in the address hold appears at the first deselect slot as a changed bank or address.

// File: rtl/ddr_ilv_pkg.sv
package ddr_ilv_pkg;

    typedef enum logic [1:0] {
        CMD_DES = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RDA = 2'd2
    } cmd_e;

    typedef enum logic {
        ORG_X8  = 1'b0,
        ORG_X16 = 1'b1
    } org_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    // Pin levels for each command slot
    function automatic pins_t encode_cmd(cmd_e c);
        pins_t p;
        case (c)
            CMD_ACT: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
            CMD_RDA: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
            default: p = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return p;
    endfunction

    function automatic int max_int(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ilv_slot_seq.sv
module ilv_slot_seq
    import ddr_ilv_pkg::*;
#(
    parameter int NUM_BANKS  = 8,
    parameter int GROUP      = 4,
    parameter int EXTRA_IDLE = 2,
    parameter int SPB_X8     = 3,
    parameter int SPB_X16    = 4,
    localparam int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              org_x16,
    output cmd_e              slot_cmd,
    output logic [BANK_W-1:0] slot_bank,
    output logic              slot_last
);

    localparam int MAX_LEN = max_int(SPB_X8, SPB_X16) + EXTRA_IDLE;
    localparam int SUB_W   = $clog2(MAX_LEN + 1);

    logic [BANK_W-1:0] bank_q;
    logic [SUB_W-1:0]  sub_q;
    org_e              org_q;
    logic [SUB_W-1:0]  len;
    logic              grp_end;
    logic              bank_done;

    always_comb begin
        len       = (org_q == ORG_X16) ? SUB_W'(SPB_X16) : SUB_W'(SPB_X8);
        grp_end   = ((int'(bank_q) % GROUP) == (GROUP - 1));
        if (grp_end) begin
            len = len + SUB_W'(EXTRA_IDLE);
        end
        bank_done = (sub_q == (len - SUB_W'(1)));
        slot_last = bank_done && (bank_q == BANK_W'(NUM_BANKS - 1));
        if (sub_q == '0) begin
            slot_cmd = CMD_ACT;
        end else if (sub_q == SUB_W'(1)) begin
            slot_cmd = CMD_RDA;
        end else begin
            slot_cmd = CMD_DES;
        end
    end

    assign slot_bank = bank_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            bank_q <= '0;
            sub_q  <= '0;
            org_q  <= org_e'(org_x16);
        end else if (bank_done) begin
            sub_q  <= '0;
            bank_q <= slot_last ? '0 : bank_q + BANK_W'(1);
        end else begin
            sub_q  <= sub_q + SUB_W'(1);
        end
    end

endmodule

// File: rtl/ilv_cmd_enc.sv
module ilv_cmd_enc
    import ddr_ilv_pkg::*;
(
    input  logic  run,
    input  cmd_e  cmd,
    output pins_t pins
);

    always_comb begin
        pins = run ? encode_cmd(cmd) : encode_cmd(CMD_DES);
    end

endmodule

// File: rtl/ilv_addr_hold.sv
module ilv_addr_hold
    import ddr_ilv_pkg::*;
#(
    parameter int BANK_W   = 3,
    parameter int ADDR_W   = 14,
    parameter int ROW_ADDR = 'h1A5,
    parameter int COL_ADDR = 'h008,
    parameter int AP_BIT   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  cmd_e              cmd,
    input  logic [BANK_W-1:0] bank_in,
    output logic [BANK_W-1:0] ba_q,
    output logic [ADDR_W-1:0] addr_q
);

    localparam logic [ADDR_W-1:0] ROW_WORD = ADDR_W'(ROW_ADDR);
    localparam logic [ADDR_W-1:0] RD_WORD  = ADDR_W'(COL_ADDR) | (ADDR_W'(1) << AP_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ba_q   <= '0;
            addr_q <= '0;
        end else if (run && cmd == CMD_ACT) begin
            ba_q   <= bank_in;
            addr_q <= ROW_WORD;
        end else if (run && cmd == CMD_RDA) begin
            ba_q   <= bank_in;
            addr_q <= RD_WORD;
        end
    end

endmodule

// File: rtl/ddr_ilv_gen.sv
module ddr_ilv_gen
    import ddr_ilv_pkg::*;
#(
    parameter int NUM_BANKS  = 8,
    parameter int GROUP      = 4,
    parameter int EXTRA_IDLE = 2,
    parameter int SPB_X8     = 3,
    parameter int SPB_X16    = 4,
    parameter int ADDR_W     = 14,
    parameter int ROW_ADDR   = 'h1A5,
    parameter int COL_ADDR   = 'h008,
    parameter int AP_BIT     = 10,
    localparam int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              org_x16,
    output logic              ddr_cs_n,
    output logic              ddr_ras_n,
    output logic              ddr_cas_n,
    output logic              ddr_we_n,
    output logic [BANK_W-1:0] ddr_ba,
    output logic [ADDR_W-1:0] ddr_addr,
    output logic              pass_wrap
);

    cmd_e              slot_cmd;
    logic [BANK_W-1:0] slot_bank;
    logic              slot_last;
    pins_t             pins_nx;
    pins_t             pins_q;
    logic              wrap_q;

    ilv_slot_seq #(
        .NUM_BANKS (NUM_BANKS),
        .GROUP     (GROUP),
        .EXTRA_IDLE(EXTRA_IDLE),
        .SPB_X8    (SPB_X8),
        .SPB_X16   (SPB_X16)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .run      (en),
        .org_x16  (org_x16),
        .slot_cmd (slot_cmd),
        .slot_bank(slot_bank),
        .slot_last(slot_last)
    );

    ilv_cmd_enc u_enc (
        .run (en),
        .cmd (slot_cmd),
        .pins(pins_nx)
    );

    ilv_addr_hold #(
        .BANK_W  (BANK_W),
        .ADDR_W  (ADDR_W),
        .ROW_ADDR(ROW_ADDR),
        .COL_ADDR(COL_ADDR),
        .AP_BIT  (AP_BIT)
    ) u_addr (
        .clk    (clk),
        .rst    (rst),
        .run    (en),
        .cmd    (slot_cmd),
        .bank_in(slot_bank),
        .ba_q   (ddr_ba),
        .addr_q (ddr_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q <= encode_cmd(CMD_DES);
            wrap_q <= 1'b0;
        end else begin
            pins_q <= pins_nx;
            wrap_q <= en && slot_last;
        end
    end

    assign ddr_cs_n  = pins_q.cs_n;
    assign ddr_ras_n = pins_q.ras_n;
    assign ddr_cas_n = pins_q.cas_n;
    assign ddr_we_n  = pins_q.we_n;
    assign pass_wrap = wrap_q;

endmodule

// File: rtl/ddr_ilv_chk.sv
module ddr_ilv_chk #(
    parameter int BANK_W = 3,
    parameter int ADDR_W = 14,
    parameter int AP_BIT = 10,
    parameter int SPB_X8 = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              ddr_cs_n,
    input logic              ddr_ras_n,
    input logic              ddr_cas_n,
    input logic              ddr_we_n,
    input logic [BANK_W-1:0] ddr_ba,
    input logic [ADDR_W-1:0] ddr_addr,
    input logic              pass_wrap
);

    logic is_act;
    logic is_rda;
    logic [7:0] gap_q;
    logic       seen_q;

    assign is_act = !ddr_cs_n && !ddr_ras_n && ddr_cas_n && ddr_we_n;
    assign is_rda = !ddr_cs_n && ddr_ras_n && !ddr_cas_n && ddr_we_n;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (is_act) begin
            gap_q  <= 8'd1;
            seen_q <= 1'b1;
        end else if (gap_q != 8'hFF) begin
            gap_q  <= gap_q + 8'd1;
        end
    end

    // R2
    act_then_rda_chk: assert property (@(posedge clk) disable iff (rst)
        (is_act && en) |=> (is_rda && $stable(ddr_ba)));

    // R3
    legal_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        !ddr_cs_n |-> (is_act || is_rda));

    // R4
    rda_autopre_chk: assert property (@(posedge clk) disable iff (rst)
        is_rda |-> ddr_addr[AP_BIT]);

    // R5
    act_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (is_act && seen_q) |-> (gap_q >= 8'(SPB_X8)));

    // R9
    des_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ddr_cs_n |-> ($stable(ddr_ba) && $stable(ddr_addr)));

    // R10
    wrap_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pass_wrap |=> !pass_wrap);

    // R10
    wrap_on_des_chk: assert property (@(posedge clk) disable iff (rst)
        pass_wrap |-> ddr_cs_n);

    // R11
    idle_des_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (ddr_cs_n && !pass_wrap));

endmodule

bind ddr_ilv_gen ddr_ilv_chk #(
    .BANK_W(BANK_W),
    .ADDR_W(ADDR_W),
    .AP_BIT(AP_BIT),
    .SPB_X8(SPB_X8)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .ddr_cs_n (ddr_cs_n),
    .ddr_ras_n(ddr_ras_n),
    .ddr_cas_n(ddr_cas_n),
    .ddr_we_n (ddr_we_n),
    .ddr_ba   (ddr_ba),
    .ddr_addr (ddr_addr),
    .pass_wrap(pass_wrap)
);

// File: tb/ddr_ilv_gen_tb.sv
`timescale 1ns/1ps
module ddr_ilv_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        org_x16 = 1'b0;
    logic        ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
    logic [2:0]  ddr_ba;
    logic [13:0] ddr_addr;
    logic        pass_wrap;

    always #2.5 clk = ~clk;

    ddr_ilv_gen u_dut (
        .clk(clk), .rst(rst), .en(en), .org_x16(org_x16),
        .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n),
        .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n),
        .ddr_ba(ddr_ba), .ddr_addr(ddr_addr), .pass_wrap(pass_wrap)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h @%0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model: a queue of slots for one pass
    int  q_kind[$];  // 0 des, 1 act, 2 rda
    int  q_bank[$];
    int  m_org = 0;
    int  e_kind = 0;
    int  e_ba = 0;
    int  e_addr = 0;
    bit  e_wrap = 0;
    int  cyc = 0;
    bit  started = 0;
    int  act_hist[$];
    int  last_act[8];
    int  last_wrap = -1;

    function automatic void build_pass(int org);
        int spb;
        spb = org ? 4 : 3;
        for (int b = 0; b < 8; b++) begin
            q_kind.push_back(1); q_bank.push_back(b);
            q_kind.push_back(2); q_bank.push_back(b);
            for (int k = 2; k < spb; k++) begin
                q_kind.push_back(0); q_bank.push_back(b);
            end
            if (b % 4 == 3) begin
                for (int k = 0; k < 2; k++) begin
                    q_kind.push_back(0); q_bank.push_back(b);
                end
            end
        end
    endfunction

    always @(posedge clk) begin
        cyc++;
        started = 1;
        if (rst || !en) begin
            e_kind = 0;
            e_wrap = 0;
            q_kind.delete();
            q_bank.delete();
            m_org = int'(org_x16);
            act_hist.delete();
            for (int b = 0; b < 8; b++) last_act[b] = -1;
            last_wrap = -1;
            if (rst) begin
                e_ba = 0;
                e_addr = 0;
            end
        end else begin
            int b;
            if (q_kind.size() == 0) build_pass(m_org);
            e_kind = q_kind.pop_front();
            b = q_bank.pop_front();
            e_wrap = (q_kind.size() == 0);
            if (e_kind == 1) begin e_ba = b; e_addr = 'h01A5; end
            if (e_kind == 2) begin e_ba = b; e_addr = 'h0408; end
        end
    end

    always @(negedge clk) begin
        if (started && !finished) begin
            int got;
            int exp;
            got = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};
            exp = (e_kind == 1) ? 'b0011 : (e_kind == 2) ? 'b0101 : 'b1111;
            check(got == exp, "R3", "command pins", got, exp);
            check(int'(ddr_ba) == e_ba, (e_kind == 0) ? "R9" : "R2", "bank", ddr_ba, e_ba);
            check(int'(ddr_addr) == e_addr, (e_kind == 0) ? "R9" : "R4", "address", ddr_addr, e_addr);
            check(pass_wrap == e_wrap, "R10", "wrap pulse", pass_wrap, e_wrap);
            if (got == 'b0011 && e_kind == 1) begin
                int spb_m;
                int win;
                int plen;
                spb_m = m_org ? 4 : 3;
                win   = m_org ? 18 : 14;
                plen  = m_org ? 36 : 28;
                if (act_hist.size() > 0) begin
                    int g;
                    g = cyc - act_hist[act_hist.size()-1];
                    check(g == spb_m || g == spb_m + 2, "R5/R6", "activate gap", g, spb_m);
                end
                if (act_hist.size() >= 4) begin
                    int w;
                    w = cyc - act_hist[act_hist.size()-4];
                    check(w >= win, "R7", "five-activate span", w, win);
                end
                if (last_act[ddr_ba] >= 0) begin
                    int s;
                    s = cyc - last_act[ddr_ba];
                    check(s == plen && s >= 23, "R8", "same-bank spacing", s, plen);
                end
                act_hist.push_back(cyc);
                last_act[ddr_ba] = cyc;
            end
            if (pass_wrap && e_wrap) begin
                int plen;
                plen = m_org ? 36 : 28;
                if (last_wrap >= 0)
                    check(cyc - last_wrap == plen, "R12", "wrap period", cyc - last_wrap, plen);
                last_wrap = cyc;
            end
        end
    end

    task automatic wait_clks(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        wait_clks(4);
        // R1: reset state
        check(ddr_cs_n == 1'b1 && ddr_ba == 3'd0 && ddr_addr == 14'd0 && !pass_wrap,
              "R1", "reset state", {ddr_cs_n, ddr_ba}, 'h8);
        rst = 1'b0;
        wait_clks(1);
        check(ddr_cs_n == 1'b1, "R1", "first clock after reset", ddr_cs_n, 1);
        // by-8 run; R5
        en = 1'b1;
        wait_clks(40);
        org_x16 = 1'b1;   // R12: must not take effect mid-run
        wait_clks(60);
        en = 1'b0;        // R11
        wait_clks(1);
        for (int i = 0; i < 3; i++) begin
            wait_clks(1);
            check(ddr_cs_n == 1'b1 && !pass_wrap, "R11", "idle deselect", ddr_cs_n, 1);
        end
        // by-16 run; R6
        en = 1'b1;
        wait_clks(1);
        check(ddr_ba == 3'd0 && ddr_cs_n == 1'b0, "R11", "restart at bank 0", ddr_ba, 0);
        wait_clks(120);
        en = 1'b0;
        wait_clks(2);
        en = 1'b1;
        wait_clks(25);
        org_x16 = 1'b0;
        rst = 1'b1;
        wait_clks(2);
        rst = 1'b0;
        wait_clks(70);
        en = 1'b0;
        wait_clks(3);
        finish_run();
    end

endmodule